// File: doc/BRIEF.md
# Counter-Driven Sequence Controller

This block is a small finite-state controller whose only state storage is a loadable binary counter. Each state holds a straight binary code, with the rest state at code zero. On every clock edge the controller moves by one of four counter operations: it clears to zero, counts up by one, loads a fixed jump target, or holds the present value. The next-state logic never builds a full next-state vector. It raises clear, load and count requests, and the counter settles them by a fixed priority.

The default sequence has ten states. State 0 idles until a start condition arrives. State 1 either steps on or, when a skip condition is present, jumps to state 6. States 2 to 4 and 6 to 8 step on unconditionally. State 5 loops on itself while a wait condition is present. State 9 returns to 0. An abort condition sends any state back to 0. Four Moore outputs are decoded from the registered code. The positions of the jump source, the self-loop, the jump target and the final state are parameters.

Top module: `ctr_seq_fsm`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge sets `state_o` to 0 at that edge. This reset is synchronous and applies from any state.
- R2: In state 0, `state_o` stays 0 while `cond_start` is low. With `cond_start` high and `cond_abort` low, the next state is 1.
- R3: States 2, 3, 4, 6, 7 and 8 advance by exactly one code per clock when `cond_abort` is low. In state 1 with `cond_skip` low, the next state is 2.
- R4: In state 1 with `cond_skip` high and `cond_abort` low, the next state is 6. This is a jump made by load, and it takes priority over the count request that state 1 also raises.
- R5: State 5 holds its code while `cond_wait` is high. When `cond_wait` is low it moves to state 6. In both cases `cond_abort` is low.
- R6: State 9 moves to state 0 on the next clock by a clear.
- R7: When `cond_abort` is high, the next state is 0 from any state. Clear overrides load, count and hold requests that arrive in the same cycle.
- R8: Each condition input acts only in its own state: `cond_start` in state 0, `cond_skip` in state 1 and `cond_wait` in state 5. In every other state these inputs do not change the next state.
- R9: The Moore outputs depend only on `state_o`. `busy_o` is high when the code is not 0. `leg_a_o` is high for codes 2 to 5. `leg_b_o` is high for codes 6 to 8. `last_o` is high for code 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_start | input | 1 | Leave the idle state |
| cond_skip | input | 1 | Jump from the branch state to the jump target |
| cond_wait | input | 1 | Keep the self-loop state |
| cond_abort | input | 1 | Return to state 0 from anywhere |
| state_o | output | 4 | Current state code (STATE_W bits) |
| busy_o | output | 1 | State is not 0 |
| leg_a_o | output | 1 | State is in the first leg (codes 2 to 5) |
| leg_b_o | output | 1 | State is in the second leg (codes 6 to 8) |
| last_o | output | 1 | State is the final state |

## Verification
Two kinds of cycle raise more than one request at once. In the branch state, load and count are both requested, and the load must win. Whenever abort is high together with skip, wait or an ordinary step, clear must beat whatever else is requested. The directed part of the bench applies skip and abort together in state 1, and wait and abort together in state 5. A long random stretch then applies abort together with the other conditions in every state. A behavioural reference model predicts the code and the four outputs, and the bench compares them with the design on every clock.

// File: rtl/ctr_seq_pkg.sv
// Package: types shared by the counter-driven sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package ctr_seq_pkg;

    // The operation the state counter carries out on one clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

    // Raw requests from the transition decoder. More than one may be set.
    typedef struct packed {
        logic clr;
        logic ld;
        logic cnt;
    } ctr_req_t;

endpackage

// File: rtl/seq_action_dec.sv
// Module: seq_action_dec
// Maps the present state code and the condition inputs to counter requests
// and a load target. It never forms a next-state vector.
// Assumes: 0 < SRC_ST < HOLD_ST < LAST_ST < 2**STATE_W, DST_ST lies in
// (HOLD_ST, LAST_ST), and all codes between SRC_ST and LAST_ST are in use.
module seq_action_dec #(
    parameter int STATE_W = 4,
    parameter int SRC_ST  = 1,
    parameter int HOLD_ST = 5,
    parameter int DST_ST  = 6,
    parameter int LAST_ST = 9
) (
    input  logic [STATE_W-1:0]     cur_st,
    input  logic                   c_start,
    input  logic                   c_skip,
    input  logic                   c_wait,
    input  logic                   c_abort,
    output ctr_seq_pkg::ctr_req_t  req,
    output logic [STATE_W-1:0]     ld_target
);
    localparam logic [STATE_W-1:0] K_IDLE = '0;
    localparam logic [STATE_W-1:0] K_SRC  = STATE_W'(SRC_ST);
    localparam logic [STATE_W-1:0] K_HOLD = STATE_W'(HOLD_ST);
    localparam logic [STATE_W-1:0] K_DST  = STATE_W'(DST_ST);
    localparam logic [STATE_W-1:0] K_LAST = STATE_W'(LAST_ST);

    ctr_seq_pkg::ctr_req_t base_req;

    // Per-state requests before abort is applied.
    always_comb begin
        base_req = '0;
        if (cur_st == K_IDLE) begin
            base_req.cnt = c_start;
        end else if (cur_st == K_SRC) begin
            base_req.cnt = 1'b1;
            base_req.ld  = c_skip;
        end else if (cur_st == K_HOLD) begin
            base_req.cnt = ~c_wait;
        end else if (cur_st == K_LAST) begin
            base_req.clr = 1'b1;
        end else if ((cur_st > K_SRC) && (cur_st < K_LAST)) begin
            base_req.cnt = 1'b1;
        end else begin
            base_req.clr = 1'b1;
        end
    end

    // Abort adds a clear on top of any request already raised.
    always_comb begin
        req     = base_req;
        req.clr = base_req.clr | c_abort;
    end

    // The jump target is the only load value; it matters only while ld is set.
    assign ld_target = K_DST;

endmodule

// File: rtl/seq_state_ctr.sv
// Module: seq_state_ctr
// A loadable binary counter that holds the state code. It settles the
// requests by priority: clear, then load, then count, then hold.
// Assumes: synchronous active-low reset; wrap-around on count is not used.
module seq_state_ctr #(
    parameter int STATE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  ctr_seq_pkg::ctr_req_t  req,
    input  logic [STATE_W-1:0]     ld_data,
    output logic [STATE_W-1:0]     q
);
    ctr_seq_pkg::ctr_op_e  op;
    logic [STATE_W-1:0]    q_nxt;

    // Select one operation from the request set.
    always_comb begin
        if (req.clr)      op = ctr_seq_pkg::OP_CLEAR;
        else if (req.ld)  op = ctr_seq_pkg::OP_LOAD;
        else if (req.cnt) op = ctr_seq_pkg::OP_COUNT;
        else              op = ctr_seq_pkg::OP_HOLD;
    end

    // Carry out the selected operation.
    always_comb begin
        case (op)
            ctr_seq_pkg::OP_CLEAR: q_nxt = '0;
            ctr_seq_pkg::OP_LOAD:  q_nxt = ld_data;
            ctr_seq_pkg::OP_COUNT: q_nxt = q + 1'b1;
            default:               q_nxt = q;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/seq_moore_out.sv
// Module: seq_moore_out
// Decodes the Moore outputs from the registered state code alone.
// Assumes: the same ordering of parameters as seq_action_dec.
module seq_moore_out #(
    parameter int STATE_W = 4,
    parameter int SRC_ST  = 1,
    parameter int DST_ST  = 6,
    parameter int LAST_ST = 9
) (
    input  logic [STATE_W-1:0] st,
    output logic               busy,
    output logic               leg_a,
    output logic               leg_b,
    output logic               at_last
);
    localparam logic [STATE_W-1:0] K_SRC  = STATE_W'(SRC_ST);
    localparam logic [STATE_W-1:0] K_DST  = STATE_W'(DST_ST);
    localparam logic [STATE_W-1:0] K_LAST = STATE_W'(LAST_ST);

    // Range decode of the state code.
    always_comb begin
        busy    = (st != '0);
        leg_a   = (st > K_SRC) && (st < K_DST);
        leg_b   = (st >= K_DST) && (st < K_LAST);
        at_last = (st == K_LAST);
    end

endmodule

// File: rtl/ctr_seq_fsm.sv
// Module: ctr_seq_fsm (top)
// A sequencer whose state register is a loadable counter. The decoder picks
// clear, count, load or hold, and the counter applies the chosen operation.
// Assumes: the parameter ordering stated in seq_action_dec.
module ctr_seq_fsm #(
    parameter int STATE_W = 4,
    parameter int SRC_ST  = 1,
    parameter int HOLD_ST = 5,
    parameter int DST_ST  = 6,
    parameter int LAST_ST = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cond_start,
    input  logic               cond_skip,
    input  logic               cond_wait,
    input  logic               cond_abort,
    output logic [STATE_W-1:0] state_o,
    output logic               busy_o,
    output logic               leg_a_o,
    output logic               leg_b_o,
    output logic               last_o
);
    ctr_seq_pkg::ctr_req_t req;
    logic [STATE_W-1:0]    target;
    logic [STATE_W-1:0]    st_q;

    seq_action_dec #(
        .STATE_W (STATE_W),
        .SRC_ST  (SRC_ST),
        .HOLD_ST (HOLD_ST),
        .DST_ST  (DST_ST),
        .LAST_ST (LAST_ST)
    ) u_dec (
        .cur_st    (st_q),
        .c_start   (cond_start),
        .c_skip    (cond_skip),
        .c_wait    (cond_wait),
        .c_abort   (cond_abort),
        .req       (req),
        .ld_target (target)
    );

    seq_state_ctr #(
        .STATE_W (STATE_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .ld_data (target),
        .q       (st_q)
    );

    seq_moore_out #(
        .STATE_W (STATE_W),
        .SRC_ST  (SRC_ST),
        .DST_ST  (DST_ST),
        .LAST_ST (LAST_ST)
    ) u_out (
        .st      (st_q),
        .busy    (busy_o),
        .leg_a   (leg_a_o),
        .leg_b   (leg_b_o),
        .at_last (last_o)
    );

    assign state_o = st_q;

endmodule

// File: rtl/ctr_seq_fsm_chk.sv
// Module: ctr_seq_fsm_chk
// Temporal checks on the sequencer's ports, bound into every ctr_seq_fsm.
// Assumes: the same parameters as the top module.
module ctr_seq_fsm_chk #(
    parameter int STATE_W = 4,
    parameter int SRC_ST  = 1,
    parameter int HOLD_ST = 5,
    parameter int DST_ST  = 6,
    parameter int LAST_ST = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cond_start,
    input logic               cond_skip,
    input logic               cond_wait,
    input logic               cond_abort,
    input logic [STATE_W-1:0] state_o,
    input logic               busy_o,
    input logic               leg_a_o,
    input logic               leg_b_o,
    input logic               last_o
);
    localparam logic [STATE_W-1:0] K_SRC  = STATE_W'(SRC_ST);
    localparam logic [STATE_W-1:0] K_HOLD = STATE_W'(HOLD_ST);
    localparam logic [STATE_W-1:0] K_DST  = STATE_W'(DST_ST);
    localparam logic [STATE_W-1:0] K_LAST = STATE_W'(LAST_ST);

    p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == '0) && !cond_start |=> (state_o == '0));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o > K_SRC) && (state_o < K_LAST) && (state_o != K_HOLD) && !cond_abort
        |=> (state_o == STATE_W'($past(state_o) + 1'b1)));

    p_jump_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == K_SRC) && cond_skip && !cond_abort |=> (state_o == K_DST));

    p_self_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == K_HOLD) && cond_wait && !cond_abort |=> $stable(state_o));

    p_last_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == K_LAST) |=> (state_o == '0));

    p_abort_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cond_abort |=> (state_o == '0));

    p_legs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({leg_a_o, leg_b_o, last_o}));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(leg_a_o || leg_b_o || last_o));

endmodule

bind ctr_seq_fsm ctr_seq_fsm_chk #(
    .STATE_W (STATE_W),
    .SRC_ST  (SRC_ST),
    .HOLD_ST (HOLD_ST),
    .DST_ST  (DST_ST),
    .LAST_ST (LAST_ST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_start (cond_start),
    .cond_skip  (cond_skip),
    .cond_wait  (cond_wait),
    .cond_abort (cond_abort),
    .state_o    (state_o),
    .busy_o     (busy_o),
    .leg_a_o    (leg_a_o),
    .leg_b_o    (leg_b_o),
    .last_o     (last_o)
);

// File: tb/ctr_seq_fsm_tb.sv
// Bench: a behavioural reference model predicts the code and the outputs,
// and the bench compares them with the design on every clock.
module ctr_seq_fsm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c_start = 1'b0, c_skip = 1'b0, c_wait = 1'b0, c_abort = 1'b0;
    logic [SW-1:0] st;
    logic busy, la, lb, lst;

    int n_cmp = 0;
    int n_bad = 0;
    int m_state = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_seq_fsm u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_start (c_start),
        .cond_skip  (c_skip),
        .cond_wait  (c_wait),
        .cond_abort (c_abort),
        .state_o    (st),
        .busy_o     (busy),
        .leg_a_o    (la),
        .leg_b_o    (lb),
        .last_o     (lst)
    );

    // Expected next code from the requirements.
    function automatic int ref_next(int cur, bit r, bit s, bit k, bit w, bit a);
        if (!r) return 0;
        if (a) return 0;
        case (cur)
            0:                  return s ? 1 : 0;
            1:                  return k ? 6 : 2;
            5:                  return w ? 5 : 6;
            9:                  return 0;
            2, 3, 4, 6, 7, 8:   return cur + 1;
            default:            return 0;
        endcase
    endfunction

    // Apply one cycle of inputs at the falling edge; compare at the next falling edge.
    task automatic step(bit r, bit s, bit k, bit w, bit a, string tag);
        int nxt;
        bit e_busy, e_la, e_lb, e_lst;
        rst_n = r; c_start = s; c_skip = k; c_wait = w; c_abort = a;
        nxt = ref_next(m_state, r, s, k, w, a);
        @(posedge clk);
        @(negedge clk);
        m_state = nxt;
        e_busy = (m_state != 0);
        e_la   = (m_state >= 2) && (m_state <= 5);
        e_lb   = (m_state >= 6) && (m_state <= 8);
        e_lst  = (m_state == 9);
        n_cmp++;
        if ((int'(st) != m_state) || (busy != e_busy) || (la != e_la) ||
            (lb != e_lb) || (lst != e_lst)) begin
            n_bad++;
            $display("FAIL %s: got state=%0d busy=%0b legA=%0b legB=%0b last=%0b, expected state=%0d busy=%0b legA=%0b legB=%0b last=%0b",
                     tag, st, busy, la, lb, lst, m_state, e_busy, e_la, e_lb, e_lst);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Directed scenarios, then a random stretch.
    initial begin
        @(negedge clk);
        step(0, 1, 1, 1, 0, "R1 reset");
        step(0, 0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, 0, "R2 idle hold");
        step(1, 0, 1, 1, 0, "R2/R8 idle ignores skip and wait");
        step(1, 1, 1, 0, 0, "R2/R8 start leaves idle, skip ignored");
        step(1, 0, 0, 0, 0, "R3 branch steps on");
        step(1, 1, 1, 1, 0, "R8 conditions ignored in 2");
        step(1, 0, 1, 0, 0, "R3 step 3->4");
        step(1, 0, 0, 0, 0, "R3 step 4->5");
        step(1, 0, 0, 1, 0, "R5 self-loop");
        step(1, 1, 1, 1, 0, "R5/R8 self-loop, start and skip ignored");
        step(1, 0, 0, 1, 0, "R5 self-loop");
        step(1, 0, 0, 0, 0, "R5 leave loop");
        step(1, 0, 0, 1, 0, "R3/R8 step 6->7, wait ignored");
        step(1, 0, 0, 0, 0, "R3 step 7->8");
        step(1, 0, 0, 0, 0, "R3 step 8->9");
        step(1, 1, 1, 1, 0, "R6 final clears");
        step(1, 1, 0, 0, 0, "R2 start");
        step(1, 0, 1, 0, 0, "R4 jump by load");
        step(1, 0, 0, 0, 0, "R3 step after jump");
        step(1, 0, 0, 0, 1, "R7 abort in 7");
        step(1, 1, 0, 0, 1, "R7 abort beats start");
        step(1, 1, 0, 0, 0, "R2 start");
        step(1, 0, 1, 0, 1, "R7 abort beats load");
        step(1, 1, 0, 0, 0, "R2 start");
        step(1, 0, 0, 0, 0, "R3 to 2");
        step(1, 0, 0, 0, 0, "R3 to 3");
        step(1, 0, 0, 0, 0, "R3 to 4");
        step(1, 0, 0, 0, 0, "R3 to 5");
        step(1, 0, 0, 1, 1, "R7 abort beats hold");
        step(1, 1, 0, 0, 0, "R2 start");
        step(1, 0, 0, 0, 0, "R3 to 2");
        step(1, 0, 0, 0, 0, "R3 to 3");
        step(0, 0, 0, 0, 0, "R1 reset from 3");
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 64) != 0, $urandom % 2, $urandom % 2, ($urandom % 4) != 0,
                 ($urandom % 20) == 0, "R9 random mix");
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            summary();
            $finish;
        end
    end

endmodule